// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block drives one DMA channel through a table of 8-byte scatter-gather descriptors in memory. Software writes the table base and then sets the start bit. The walker reads each entry as two 32-bit words over a request/response memory port. It decodes the entry into a region base, a region length and a final-entry flag, and offers that region to a downstream data mover.

When the mover signals that the region has been retired, the walker moves its table pointer forward by one entry and fetches the next one. It stops in one of three ways:

- it retires the entry flagged as final, and raises done;
- it finds a fault, raises an error flag and halts;
- software clears the start bit, which aborts the walk.

Two interfaces are valid/ready. On the memory request channel, valid is held and the address is kept stable until ready is seen. Only one request is outstanding at a time. The response ready is raised only once the request has been accepted, and also while the walker is idle or finished, so that a response arriving after an abort is drained. On the region channel, valid and all region fields are held stable until ready. The downstream mover may apply back-pressure for any number of cycles. Retirement is a separate one-cycle pulse. Start, base, and the status outputs are plain levels.

Top module: `sg_walker`

## Requirements
- R1: After reset, no memory request and no region is offered, and active, done, alignment error and wrap error all read 0.
- R2: A rising edge on the start bit loads the table pointer from the base with its low three bits forced to zero. Each entry is fetched as two word reads: first the pointer (word 0, the address word), then pointer+4 (word 1, the control word).
- R3: The region address equals word 0 with bit 0 forced to zero.
- R4: Word 1 bits 15:0 hold the byte count, with bit 0 treated as zero. A resulting count of zero gives a length of 65536. Bits 30:16 of word 1 are ignored. The length output therefore lies between 2 and 65536 and is even.
- R5: On both valid/ready channels, valid stays asserted and the payload stays stable until ready is seen, unless the walk is aborted.
- R6: After the region is retired, an entry that is not final causes the next fetch at pointer+8.
- R7: Bit 31 of word 1 marks the final entry. Once that region is retired, the walker raises done, drops active, and issues no further requests.
- R8: If bit 1 of word 0 is set, the walker raises the alignment error, halts without offering that region, and does not raise done.
- R9: An entry at page offset 0xFFF8 of the 64 KB table page that is not final raises the wrap error once retired. The walker then halts without fetching outside the page. If that entry is final, the walker raises done instead.
- R10: Clearing the start bit ends any walk. From the next cycle on, no request or region is offered and active is 0.
- R11: Active is 1 from the cycle after the start edge until done, an error, or an abort.
- R12: Done and the error flags stay set after start is cleared, and are cleared only by the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command start bit; rising edge starts, low aborts |
| tbl_base | input | AW | Descriptor table base address |
| mrd_req_valid | output | 1 | Memory read request valid |
| mrd_req_ready | input | 1 | Memory read request ready |
| mrd_req_addr | output | AW | Word address of the read |
| mrd_rsp_valid | input | 1 | Read response valid |
| mrd_rsp_ready | output | 1 | Read response ready |
| mrd_rsp_data | input | DW | Read response word |
| rgn_valid | output | 1 | Region offer valid |
| rgn_ready | input | 1 | Region accepted by mover |
| rgn_addr | output | AW | Region base address |
| rgn_len | output | CW+1 | Region length in bytes |
| rgn_last | output | 1 | Region is from the final entry |
| rgn_retired | input | 1 | One-cycle pulse: mover has retired the region |
| st_active | output | 1 | Walk in progress |
| st_done | output | 1 | Final entry retired |
| st_err_align | output | 1 | Misaligned region address seen |
| st_err_wrap | output | 1 | Table pointer reached the end of its page |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses and data, a 16-bit count field, and a 64 KB table page. With a 16-bit count field, the zero-means-maximum length case and the 0xFFFF boundary fall out of ordinary entry values. The page end is reached by placing the table base at offset 0xFFF0, so the wrap error and its final-entry exemption each take only two entries rather than thousands. Random ready and latency on both channels exercise the hold rules under back-pressure.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;

  typedef enum logic [2:0] {
    S_IDLE        = 3'd0,
    S_FETCH_LO    = 3'd1,
    S_FETCH_HI    = 3'd2,
    S_ISSUE       = 3'd3,
    S_WAIT_RETIRE = 3'd4,
    S_DONE        = 3'd5
  } sgw_state_e;

endpackage

// File: rtl/sgw_entry.sv
`timescale 1ns/1ps
// Captures the two words of one descriptor and decodes them.
module sgw_entry #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] ent_addr,
  output logic [CW:0]   ent_len,
  output logic          ent_last,
  output logic          ent_misaligned
);
  localparam int LW = CW + 1;

  logic [AW-1:1] lo_q;
  logic [CW-1:1] cnt_q;
  logic          last_q;
  logic [CW-1:0] cnt_even;
  logic          unused_bits;

  assign unused_bits = ^{word[0], word[DW-2:CW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      if (cap_lo) lo_q <= word[AW-1:1];
      if (cap_hi) begin
        cnt_q  <= word[CW-1:1];
        last_q <= word[DW-1];
      end
    end
  end

  assign cnt_even       = {cnt_q, 1'b0};
  assign ent_addr       = {lo_q, 1'b0};
  assign ent_misaligned = lo_q[1];
  assign ent_last       = last_q;
  assign ent_len        = (cnt_even == '0) ? {1'b1, {CW{1'b0}}} : LW'(cnt_even);
endmodule

// File: rtl/sgw_tblptr.sv
`timescale 1ns/1ps
// Table pointer: advances one entry at a time inside its page.
module sgw_tblptr #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:3] load_addr,
  input  logic          step,
  input  logic          hi_sel,
  output logic [AW-1:0] fetch_addr,
  output logic          at_page_end
);
  localparam int OFFW = PAGE_BITS - 3;

  logic [AW-1:3] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_addr;
    end else if (step) begin
      ptr_q[PAGE_BITS-1:3] <= ptr_q[PAGE_BITS-1:3] + OFFW'(1);
    end
  end

  assign fetch_addr  = {ptr_q, hi_sel, 2'b00};
  assign at_page_end = &ptr_q[PAGE_BITS-1:3];
endmodule

// File: rtl/sgw_fsm.sv
`timescale 1ns/1ps
// Walk sequencer: fetch, issue, wait for retirement, terminate.
module sgw_fsm
  import sgw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic rgn_ready,
  input  logic rgn_retired,
  input  logic ent_misaligned,
  input  logic ent_last,
  input  logic at_page_end,
  output logic req_valid,
  output logic rsp_ready,
  output logic hi_sel,
  output logic cap_lo,
  output logic cap_hi,
  output logic ptr_load,
  output logic ptr_step,
  output logic rgn_valid,
  output logic active,
  output logic done,
  output logic err_align,
  output logic err_wrap
);
  sgw_state_e st_q, st_n;
  logic start_q, start_rise, req_sent_q;
  logic set_done, set_align, set_wrap, in_fetch;

  assign start_rise = cmd_start & ~start_q;
  assign in_fetch   = (st_q == S_FETCH_LO) || (st_q == S_FETCH_HI);

  always_comb begin
    st_n      = st_q;
    ptr_load  = 1'b0;
    ptr_step  = 1'b0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    set_done  = 1'b0;
    set_align = 1'b0;
    set_wrap  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_rise) begin
          st_n     = S_FETCH_LO;
          ptr_load = 1'b1;
        end
      end
      S_FETCH_LO: begin
        if (req_sent_q && rsp_valid) begin
          cap_lo = 1'b1;
          st_n   = S_FETCH_HI;
        end
      end
      S_FETCH_HI: begin
        if (req_sent_q && rsp_valid) begin
          cap_hi = 1'b1;
          if (ent_misaligned) begin
            set_align = 1'b1;
            st_n      = S_DONE;
          end else begin
            st_n = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        if (rgn_ready) st_n = S_WAIT_RETIRE;
      end
      S_WAIT_RETIRE: begin
        if (rgn_retired) begin
          if (ent_last) begin
            set_done = 1'b1;
            st_n     = S_DONE;
          end else if (at_page_end) begin
            set_wrap = 1'b1;
            st_n     = S_DONE;
          end else begin
            ptr_step = 1'b1;
            st_n     = S_FETCH_LO;
          end
        end
      end
      S_DONE: begin
        if (!cmd_start) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
    if (!cmd_start && st_q != S_IDLE) begin
      st_n      = S_IDLE;
      ptr_step  = 1'b0;
      cap_lo    = 1'b0;
      cap_hi    = 1'b0;
      set_done  = 1'b0;
      set_align = 1'b0;
      set_wrap  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      start_q    <= 1'b0;
      req_sent_q <= 1'b0;
      done       <= 1'b0;
      err_align  <= 1'b0;
      err_wrap   <= 1'b0;
    end else begin
      st_q    <= st_n;
      start_q <= cmd_start;
      if (st_n != st_q)               req_sent_q <= 1'b0;
      else if (req_valid && req_ready) req_sent_q <= 1'b1;
      if (ptr_load) begin
        done      <= 1'b0;
        err_align <= 1'b0;
        err_wrap  <= 1'b0;
      end else begin
        if (set_done)  done      <= 1'b1;
        if (set_align) err_align <= 1'b1;
        if (set_wrap)  err_wrap  <= 1'b1;
      end
    end
  end

  assign req_valid = in_fetch && !req_sent_q;
  assign rsp_ready = (in_fetch && req_sent_q) || (st_q == S_IDLE) || (st_q == S_DONE);
  assign hi_sel    = (st_q == S_FETCH_HI);
  assign rgn_valid = (st_q == S_ISSUE);
  assign active    = in_fetch || (st_q == S_ISSUE) || (st_q == S_WAIT_RETIRE);
endmodule

// File: rtl/sg_walker.sv
`timescale 1ns/1ps
module sg_walker #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int PAGE_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] tbl_base,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [AW-1:0] mrd_req_addr,
  input  logic          mrd_rsp_valid,
  output logic          mrd_rsp_ready,
  input  logic [DW-1:0] mrd_rsp_data,
  output logic          rgn_valid,
  input  logic          rgn_ready,
  output logic [AW-1:0] rgn_addr,
  output logic [CW:0]   rgn_len,
  output logic          rgn_last,
  input  logic          rgn_retired,
  output logic          st_active,
  output logic          st_done,
  output logic          st_err_align,
  output logic          st_err_wrap
);
  logic cap_lo, cap_hi, ptr_load, ptr_step, hi_sel;
  logic ent_misaligned, at_page_end;
  logic unused_base;

  assign unused_base = ^tbl_base[2:0];

  sgw_entry #(.AW(AW), .DW(DW), .CW(CW)) u_entry (
    .clk            (clk),
    .rst_n          (rst_n),
    .cap_lo         (cap_lo),
    .cap_hi         (cap_hi),
    .word           (mrd_rsp_data),
    .ent_addr       (rgn_addr),
    .ent_len        (rgn_len),
    .ent_last       (rgn_last),
    .ent_misaligned (ent_misaligned)
  );

  sgw_tblptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ptr_load),
    .load_addr   (tbl_base[AW-1:3]),
    .step        (ptr_step),
    .hi_sel      (hi_sel),
    .fetch_addr  (mrd_req_addr),
    .at_page_end (at_page_end)
  );

  sgw_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_start      (cmd_start),
    .req_ready      (mrd_req_ready),
    .rsp_valid      (mrd_rsp_valid),
    .rgn_ready      (rgn_ready),
    .rgn_retired    (rgn_retired),
    .ent_misaligned (ent_misaligned),
    .ent_last       (rgn_last),
    .at_page_end    (at_page_end),
    .req_valid      (mrd_req_valid),
    .rsp_ready      (mrd_rsp_ready),
    .hi_sel         (hi_sel),
    .cap_lo         (cap_lo),
    .cap_hi         (cap_hi),
    .ptr_load       (ptr_load),
    .ptr_step       (ptr_step),
    .rgn_valid      (rgn_valid),
    .active         (st_active),
    .done           (st_done),
    .err_align      (st_err_align),
    .err_wrap       (st_err_wrap)
  );
endmodule

// File: rtl/sgw_chk.sv
`timescale 1ns/1ps
module sgw_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          mrd_req_valid,
  input logic          mrd_req_ready,
  input logic [AW-1:0] mrd_req_addr,
  input logic          rgn_valid,
  input logic          rgn_ready,
  input logic [AW-1:0] rgn_addr,
  input logic [CW:0]   rgn_len,
  input logic          rgn_last,
  input logic          st_active,
  input logic          st_done,
  input logic          st_err_align,
  input logic          st_err_wrap
);
  // R5
  rgn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_valid && !rgn_ready && cmd_start |=>
      rgn_valid && $stable(rgn_addr) && $stable(rgn_len) && $stable(rgn_last));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req_valid && !mrd_req_ready && cmd_start |=> mrd_req_valid && $stable(mrd_req_addr));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_valid |-> (rgn_len != '0) && !rgn_len[0] && (rgn_len <= {1'b1, {CW{1'b0}}}));

  // R3
  rgn_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_valid |-> rgn_addr[1:0] == 2'b00);

  // R2
  req_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req_valid |-> mrd_req_addr[1:0] == 2'b00);

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> !rgn_valid && !mrd_req_valid && !st_active);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> !st_err_align && !st_err_wrap);

  // R11
  active_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_active |-> !st_done && !st_err_align && !st_err_wrap);

  // R10
  no_dual_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrd_req_valid && rgn_valid));
endmodule

bind sg_walker sgw_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_start     (cmd_start),
  .mrd_req_valid (mrd_req_valid),
  .mrd_req_ready (mrd_req_ready),
  .mrd_req_addr  (mrd_req_addr),
  .rgn_valid     (rgn_valid),
  .rgn_ready     (rgn_ready),
  .rgn_addr      (rgn_addr),
  .rgn_len       (rgn_len),
  .rgn_last      (rgn_last),
  .st_active     (st_active),
  .st_done       (st_done),
  .st_err_align  (st_err_align),
  .st_err_wrap   (st_err_wrap)
);

// File: tb/sim_sg_walker.sv
`timescale 1ns/1ps
module sim_sg_walker;
  localparam int AW = 32, DW = 32, CW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, cmd_start;
  logic [AW-1:0] tbl_base;
  logic          mrd_req_valid, mrd_req_ready, mrd_rsp_valid, mrd_rsp_ready;
  logic [AW-1:0] mrd_req_addr;
  logic [DW-1:0] mrd_rsp_data;
  logic          rgn_valid, rgn_ready, rgn_last, rgn_retired;
  logic [AW-1:0] rgn_addr;
  logic [CW:0]   rgn_len;
  logic          st_active, st_done, st_err_align, st_err_wrap;

  sg_walker u0 (.*);

  int vectors = 0;
  int fails   = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] req_log[$];
  logic [31:0] rg_addr_log[$];
  logic [16:0] rg_len_log[$];
  logic        rg_last_log[$];

  logic [31:0] ent_addr [16];
  logic [15:0] ent_cnt  [16];
  logic        ent_eot  [16];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_len(input logic [15:0] c);
    logic [15:0] e;
    e = {c[15:1], 1'b0};
    return (e == 16'd0) ? 17'h10000 : {1'b0, e};
  endfunction

  // Memory responder: one request at a time, random ready and latency.
  logic        req_fire = 1'b0, rsp_fire = 1'b0, pend = 1'b0;
  logic [31:0] req_a, pdata;
  int          lat;
  initial begin
    mrd_req_ready = 1'b0; mrd_rsp_valid = 1'b0; mrd_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rsp_fire) mrd_rsp_valid = 1'b0;
      if (req_fire) begin
        pend  = 1'b1;
        lat   = int'($urandom % 3);
        pdata = mem.exists(req_a) ? mem[req_a] : 32'd0;
        req_log.push_back(req_a);
      end
      if (pend && !mrd_rsp_valid) begin
        if (lat == 0) begin
          mrd_rsp_valid = 1'b1; mrd_rsp_data = pdata; pend = 1'b0;
        end else lat--;
      end
      mrd_req_ready = (!pend && !mrd_rsp_valid) ? ($urandom % 4 != 0) : 1'b0;
      #1;
      req_fire = mrd_req_valid && mrd_req_ready;
      req_a    = mrd_req_addr;
      rsp_fire = mrd_rsp_valid && mrd_rsp_ready;
    end
  end

  // Mover model: random ready, retire pulse a few cycles after acceptance.
  logic        rg_fire = 1'b0;
  logic [31:0] rg_a;
  logic [16:0] rg_l;
  logic        rg_e;
  int          ret_wait = -1;
  initial begin
    rgn_ready = 1'b0; rgn_retired = 1'b0;
    forever begin
      @(negedge clk);
      rgn_retired = 1'b0;
      if (rg_fire) begin
        rg_addr_log.push_back(rg_a); rg_len_log.push_back(rg_l); rg_last_log.push_back(rg_e);
        ret_wait = int'($urandom % 3);
      end else if (ret_wait == 0) begin
        rgn_retired = 1'b1; ret_wait = -1;
      end else if (ret_wait > 0) ret_wait--;
      rgn_ready = ($urandom % 3 != 0);
      #1;
      rg_fire = rgn_valid && rgn_ready;
      rg_a = rgn_addr; rg_l = rgn_len; rg_e = rgn_last;
    end
  end

  task automatic load_table(input logic [31:0] base, input int n);
    logic [31:0] b;
    b = base & ~32'h7;
    mem.delete();
    for (int i = 0; i < n; i++) begin
      mem[b + 32'(8*i)]     = ent_addr[i];
      mem[b + 32'(8*i) + 4] = {ent_eot[i], 15'($urandom), ent_cnt[i]};
    end
    req_log.delete(); rg_addr_log.delete(); rg_len_log.delete(); rg_last_log.delete();
  endtask

  task automatic run_case(input logic [31:0] base, input int n);
    logic [31:0] b;
    int stop, nreg;
    logic e_done, e_al, e_wr;
    b = base & ~32'h7;
    load_table(base, n);
    @(negedge clk); cmd_start = 1'b1; tbl_base = base;
    @(negedge clk);
    check("R12 flags cleared by start", {st_done, st_err_align, st_err_wrap}, 0);
    check("R11 active after start", st_active, 1);
    for (int k = 0; k < 20000 && st_active; k++) @(negedge clk);
    stop = n - 1; nreg = 0; e_done = 0; e_al = 0; e_wr = 0;
    for (int i = 0; i < n; i++) begin
      if (ent_addr[i][1]) begin e_al = 1; stop = i; break; end
      nreg++;
      if (ent_eot[i]) begin e_done = 1; stop = i; break; end
      if (((b + 32'(8*i)) & 32'hFFFF) == 32'hFFF8) begin e_wr = 1; stop = i; break; end
    end
    check("R7 done flag", st_done, e_done);
    check("R8 alignment error", st_err_align, e_al);
    check("R9 wrap error", st_err_wrap, e_wr);
    check("R11 active dropped", st_active, 0);
    check("R6 region count", rg_addr_log.size(), nreg);
    for (int i = 0; i < nreg && i < rg_addr_log.size(); i++) begin
      check("R3 region address", rg_addr_log[i], {ent_addr[i][31:1], 1'b0});
      check("R4 region length", rg_len_log[i], exp_len(ent_cnt[i]));
      check("R7 region last flag", rg_last_log[i], ent_eot[i]);
    end
    check("R2 request count", req_log.size(), 2*(stop+1));
    for (int i = 0; i <= stop && 2*i+1 < req_log.size(); i++) begin
      check("R6 word0 fetch address", req_log[2*i],   b + 32'(8*i));
      check("R2 word1 fetch address", req_log[2*i+1], b + 32'(8*i) + 4);
    end
    @(negedge clk); cmd_start = 1'b0;
    repeat (8) @(negedge clk);
    check("R12 flags sticky after clear", {st_done, st_err_align, st_err_wrap}, {e_done, e_al, e_wr});
  endtask

  task automatic random_case();
    int n;
    logic [31:0] base;
    n = 1 + int'($urandom % 6);
    base = {$urandom % 32'h10000, 16'h0} | (($urandom % 32'h1000) << 3);
    for (int i = 0; i < n; i++) begin
      ent_addr[i] = ($urandom & ~32'h3) | ($urandom & 32'h1);
      ent_cnt[i]  = 16'($urandom);
      ent_eot[i]  = (i == n-1);
    end
    run_case(base, n);
  endtask

  initial begin
    int sz;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; cmd_start = 1'b0; tbl_base = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset request valid", mrd_req_valid, 0);
    check("R1 reset region valid", rgn_valid, 0);
    check("R1 reset status", {st_active, st_done, st_err_align, st_err_wrap}, 0);

    // Directed decode corners (R3, R4), base with low bits set (R2)
    ent_addr[0] = 32'h8000_0001; ent_cnt[0] = 16'h0000; ent_eot[0] = 0;
    ent_addr[1] = 32'h1234_5670; ent_cnt[1] = 16'h0001; ent_eot[1] = 0;
    ent_addr[2] = 32'hFFFF_FFFD; ent_cnt[2] = 16'h0003; ent_eot[2] = 0;
    ent_addr[3] = 32'h0000_0004; ent_cnt[3] = 16'hFFFF; ent_eot[3] = 0;
    ent_addr[4] = 32'h00AB_CD00; ent_cnt[4] = 16'h0800; ent_eot[4] = 1;
    run_case(32'h0000_1005, 5);

    for (int t = 0; t < 8; t++) random_case();

    // R8 misaligned second entry, then misaligned first entry
    ent_addr[0] = 32'h0000_2000; ent_cnt[0] = 16'h0100; ent_eot[0] = 0;
    ent_addr[1] = 32'h0000_3002; ent_cnt[1] = 16'h0100; ent_eot[1] = 0;
    ent_addr[2] = 32'h0000_4000; ent_cnt[2] = 16'h0100; ent_eot[2] = 1;
    run_case(32'h0005_0100, 3);
    ent_addr[0] = 32'h0000_0006;
    run_case(32'h0005_0200, 3);

    // R9 page end: non-final entry at 0xFFF8 wraps, final one completes
    ent_addr[0] = 32'h0001_0000; ent_cnt[0] = 16'h0040; ent_eot[0] = 0;
    ent_addr[1] = 32'h0002_0000; ent_cnt[1] = 16'h0080; ent_eot[1] = 0;
    ent_addr[2] = 32'h0003_0000; ent_cnt[2] = 16'h0080; ent_eot[2] = 1;
    run_case(32'h0003_FFF0, 3);
    ent_eot[1] = 1;
    run_case(32'h0003_FFF0, 2);
    ent_eot[0] = 0;
    run_case(32'h0007_FFF8, 1);

    // R10 abort while a region is outstanding
    ent_addr[0] = 32'h0000_1000; ent_cnt[0] = 16'h0200; ent_eot[0] = 0;
    ent_addr[1] = 32'h0000_2000; ent_cnt[1] = 16'h0200; ent_eot[1] = 0;
    ent_addr[2] = 32'h0000_3000; ent_cnt[2] = 16'h0200; ent_eot[2] = 1;
    load_table(32'h0009_0000, 3);
    @(negedge clk); cmd_start = 1'b1; tbl_base = 32'h0009_0000;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); #2;
      if (rg_addr_log.size() >= 1) break;
    end
    cmd_start = 1'b0;
    @(negedge clk); #2;
    check("R10 region valid after abort", rgn_valid, 0);
    check("R10 request valid after abort", mrd_req_valid, 0);
    check("R10 active after abort", st_active, 0);
    check("R10 done after abort", st_done, 0);
    sz = req_log.size();
    repeat (20) @(negedge clk);
    check("R10 no fetch after abort", req_log.size(), sz);
    check("R10 no region after abort", rg_addr_log.size(), 1);

    for (int t = 0; t < 3; t++) random_case();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule